// File: doc/BRIEF.md
# Linear Sensor Line Readout Sequencer

This block produces the per-line timing for a 2048-pixel linear image sensor. It needs only a clock and a start input. The start input is sampled on every clock. A line begins when a rising edge is seen while the sequencer is idle. A fixed preparation interval follows. After that, the line-valid output stays high for one clock per pixel. The optical black pixels come first, then the active pixels. A pixel index output gives the position of the pixel being read out.

The serial pixel output is active low and carries a per-pixel comparator bit supplied from outside. There are two output modes:
- **Comparator mode:** the output is aligned with line-valid.
- **Threshold mode:** the output lags line-valid by 3, 6 or 9 clocks, at both the start and the end of the line. The sequencer stays busy until the delayed tail has drained.

The mode and the delay are captured at the accepted start edge. An exposure flag shows when the sensor is integrating. It drops on the clock after an accepted start edge and rises again when line-valid falls.

Top module: `line_seq`

## Requirements
- R1: After reset, `dval` is 0, `dout_n` is 1, `pix_idx` is 0 and `expo` is 1. The captured settings are comparator mode and a delay of 3.
- R2: A line starts only when `strt` is 1 at a clock edge and was 0 at the previous edge, and only while the sequencer is idle. Holding `strt` high starts no further line.
- R3: `dval` rises on the 16th clock edge after the edge that accepted the start. This leaves 16 cycles of line preparation.
- R4: `dval` stays high for exactly 2048 consecutive cycles. `pix_idx` counts 0 to 2047, one step per cycle. Indices 0 to 11 are the optical black pixels. `pix_idx` is 0 whenever `dval` is low.
- R5: In comparator mode (`thr_mode`=0 at the start edge), `dout_n` equals the inverse of `cmp_bit` while `dval` is 1, and equals 1 otherwise.
- R6: In threshold mode, `dout_n` in cycle t equals the inverse of `cmp_bit` from cycle t−D if `dval` was 1 in cycle t−D, and equals 1 otherwise. D is set by `dly_code`: 2'b00 gives 3, 2'b01 gives 6, 2'b10 gives 9 and 2'b11 gives 3.
- R7: Mode and delay are captured at the accepted start edge. Changes to `thr_mode` and `dly_code` have no effect until the next accepted start.
- R8: A start edge that arrives while a line is in preparation, readout or delayed tail is ignored.
- R9: `expo` goes to 0 on the clock after an accepted start edge. It returns to 1 in the first cycle in which `dval` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strt | input | 1 | Line start request, sampled every clock |
| cmp_bit | input | 1 | Comparator result for the current pixel |
| thr_mode | input | 1 | 1 = threshold (delayed) output, 0 = comparator output |
| dly_code | input | 2 | Threshold output delay select |
| dval | output | 1 | Line data valid |
| dout_n | output | 1 | Serial pixel output, active low |
| pix_idx | output | 11 | Index of the pixel being read out |
| expo | output | 1 | Exposure in progress |

## Verification
The assertions check on every cycle:
- that the index steps by one during readout, starts at 0 and ends at 2047;
- that the exposure flag is low at the rise of line-valid and high at its fall;
- that the output stays idle outside line-valid in comparator mode.

The following only show up in the bench's scenarios:
- the exact 16-cycle preparation delay;
- the 3/6/9-cycle lag of the threshold output, including the mapping of code 3;
- the capture of settings at the start edge;
- the rejection of start edges during a busy line or a held-high start.

These are checked against a cycle-accurate reference model that runs under random start, comparator and setting activity.

// File: rtl/line_seq.sv
module line_seq #(
  parameter int PIXELS   = 2048,
  parameter int BLACK    = 12,
  parameter int INIT_CYC = 16,
  parameter int DLY_STEP = 3,
  localparam int CW      = $clog2(PIXELS),
  localparam int MAXD    = 3 * DLY_STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strt,
  input  logic          cmp_bit,
  input  logic          thr_mode,
  input  logic [1:0]    dly_code,
  output logic          dval,
  output logic          dout_n,
  output logic [CW-1:0] pix_idx,
  output logic          expo
);
  typedef enum logic [1:0] {IDLE, PREP, READ, TAIL} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [3:0]    tcnt;
  logic          strt_d;
  logic          mode_q;
  logic [1:0]    code_q;
  logic [MAXD-1:0] sv, sb;
  int unsigned   dly;

  wire start_ok = strt && !strt_d && st == IDLE;

  always_comb dly = (code_q == 2'd3) ? DLY_STEP : DLY_STEP * (int'(code_q) + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      tcnt   <= '0;
      strt_d <= 1'b0;
      mode_q <= 1'b0;
      code_q <= 2'd0;
      expo   <= 1'b1;
    end else begin
      strt_d <= strt;
      case (st)
        IDLE: if (start_ok) begin
          st     <= PREP;
          cnt    <= '0;
          mode_q <= thr_mode;
          code_q <= dly_code;
          expo   <= 1'b0;
        end
        PREP: if (cnt == CW'(INIT_CYC - 1)) begin
          st  <= READ;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        READ: if (cnt == CW'(PIXELS - 1)) begin
          cnt  <= '0;
          expo <= 1'b1;
          if (mode_q) begin
            st   <= TAIL;
            tcnt <= 4'd1;
          end else st <= IDLE;
        end else cnt <= cnt + 1'b1;
        TAIL: if (32'(tcnt) == dly) st <= IDLE;
              else tcnt <= tcnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv <= '0;
      sb <= '1;
    end else begin
      sv <= {sv[MAXD-2:0], dval};
      sb <= {sb[MAXD-2:0], ~cmp_bit};
    end
  end

  assign dval    = (st == READ);
  assign pix_idx = dval ? cnt : '0;
  assign dout_n  = mode_q ? (sv[dly-1] ? sb[dly-1] : 1'b1)
                          : (dval ? ~cmp_bit : 1'b1);
endmodule

module line_seq_chk #(
  parameter int PIXELS = 2048,
  localparam int CW    = $clog2(PIXELS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dval,
  input logic          dout_n,
  input logic [CW-1:0] pix_idx,
  input logic          expo,
  input logic          mode_q
);
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dval && $past(dval) |-> pix_idx == $past(pix_idx) + CW'(1));
  // R4
  idx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dval) |-> pix_idx == '0);
  // R4
  idx_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dval) |-> $past(pix_idx) == CW'(PIXELS - 1));
  // R9
  expo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dval) |-> !expo);
  // R9
  expo_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dval) |-> expo);
  // R5
  cmp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && !dval |-> dout_n);
endmodule

bind line_seq line_seq_chk #(.PIXELS(PIXELS)) chk_i (
  .clk(clk), .rst_n(rst_n), .dval(dval), .dout_n(dout_n),
  .pix_idx(pix_idx), .expo(expo), .mode_q(mode_q)
);

// File: tb/line_seq_tb.sv
module line_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, strt = 1'b0, cmp_bit = 1'b0, thr_mode = 1'b0;
  logic [1:0] dly_code = 2'd0;
  logic dval, dout_n, expo;
  logic [10:0] pix_idx;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  line_seq dut_i (.clk(clk), .rst_n(rst_n), .strt(strt), .cmp_bit(cmp_bit),
    .thr_mode(thr_mode), .dly_code(dly_code), .dval(dval), .dout_n(dout_n),
    .pix_idx(pix_idx), .expo(expo));

  always #10 clk = ~clk;

  function automatic int delay_of(input logic [1:0] c);
    case (c)
      2'd1: return 6;
      2'd2: return 9;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_ph = 0, m_cnt = 0, m_d = 3;
  logic m_mode = 0, m_expo = 1, m_sd = 0;
  logic [9:0] hv = '0, hb = '1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_d = 3; m_mode = 0; m_expo = 1; m_sd = 0; hv = '0; hb = '1;
    end else begin
      hv = {hv[8:0], m_ph == 2};
      hb = {hb[8:0], ~cmp_bit};
      if (m_ph == 0) begin
        if (strt && !m_sd) begin
          m_ph = 1; m_cnt = 0; m_mode = thr_mode; m_d = delay_of(dly_code); m_expo = 0;
        end
      end else if (m_ph == 1) begin
        if (m_cnt == 15) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
      end else if (m_ph == 2) begin
        if (m_cnt == 2047) begin
          m_expo = 1; m_cnt = 1; m_ph = m_mode ? 3 : 0;
        end else m_cnt++;
      end else begin
        if (m_cnt == m_d) m_ph = 0; else m_cnt++;
      end
      m_sd = strt;
    end
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic e_dv, e_do;
      e_dv = (m_ph == 2);
      e_do = m_mode ? (hv[m_d-1] ? hb[m_d-1] : 1'b1) : (e_dv ? ~cmp_bit : 1'b1);
      chk("R3/R8 dval", dval, e_dv);
      chk("R4 pix_idx", pix_idx, e_dv ? m_cnt : 0);
      chk(m_mode ? "R6/R7 dout_n" : "R5 dout_n", dout_n, e_do);
      chk("R9 expo", expo, m_expo);
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 dval", dval, 0); chk("R1 dout_n", dout_n, 1);
    chk("R1 pix_idx", pix_idx, 0); chk("R1 expo", expo, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 directed: preparation length, R8 mid-line edge, R2 held-high start
    thr_mode = 1'b1; dly_code = 2'd3;
    strt = 1'b1; n = 0;
    while (!dval) begin @(negedge clk); n++; end
    chk("R3 start-to-dval", n, 17);
    dly_code = 2'd2; thr_mode = 1'b0;
    n = 0;
    while (dval) begin
      @(negedge clk); n++;
      if (n == 100) strt = 1'b0;
      if (n == 101) strt = 1'b1;
    end
    chk("R4/R8 dval length", n, 2048);
    n = 0;
    repeat (3000) begin @(negedge clk); if (dval) n++; end
    chk("R2 held strt no new line", n, 0);
    strt = 1'b0;

    // directed corners: each delay code, comparator mode
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      thr_mode = (c != 4); dly_code = 2'(c);
      cmp_bit = 1'b0;
      @(negedge clk); strt = 1'b1;
      @(negedge clk); strt = 1'b0;
      repeat (2100) begin @(negedge clk); cmp_bit = 1'($urandom); end
    end

    // random traffic
    repeat (40000) begin
      @(negedge clk);
      cmp_bit = 1'($urandom);
      if ($urandom_range(0, 299) == 0) strt = ~strt;
      if ($urandom_range(0, 49) == 0) begin
        thr_mode = 1'($urandom); dly_code = 2'($urandom);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule